// File: doc/BRIEF.md
# PCI Configuration Access Sequencer

This block turns a configuration read or write request into the short series of register accesses a host bridge needs to reach PCI configuration space. A request names the bus, device, function, register offset, access size and direction. The block builds the configuration address word and writes it to the bridge's address register. It then reads or writes the bridge's data register. After every data-register read it inspects two status registers, and it clears any error bits it finds by writing them back.

The address word has one of two forms. When the target bus is the locally attached root bus, the word is a Type 0 address that carries a one-hot device select bit. For any other bus it is a Type 1 address that carries the bus number. Reads return the addressed lane, shifted down to bit 0, or all ones if the status check found an error. Byte and halfword writes are done as read-modify-write. The write is abandoned if the preceding read reported an error.

Top module: `pci_cfg_seq`

## Requirements
- R1: `req_ready` is high only while the sequencer is idle. Exactly one request is accepted per handshake. Every accepted request produces exactly one `rsp_valid` pulse lasting one cycle, and `req_ready` is low in the cycle after acceptance.
- R2: When `req_bus` equals `root_bus`, the address word is Type 0. It has bit (device+16) set when device is below 16 and no select bit when device is 16 or more. Device is in [15:11], function in [10:8], offset[7:2] in [7:2], and [1:0] = 0.
- R3: For any other bus, the address word is Type 1. Bus is in [23:16], device in [15:11], function in [10:8], offset[7:2] in [7:2], bit 1 = 0 and bit 0 = 1. Bits [31:24] are zero.
- R4: Every request begins with a master write of the address word to register 0x1A4. The data access that follows goes to register 0x1AC. Master writes and reads never strobe together.
- R5: After each data-register read, the block reads register 0x106. If `rdata & 0xF900` is nonzero, it writes exactly those bits back to 0x106. It then reads register 0x188. If `rdata & 0x679F` is nonzero, it writes exactly those bits back to 0x188. The error flag is the OR of the two checks.
- R6: A read response carries the data dword shifted right by (offset & 3) × 8. On error the response is 0xFFFFFFFF with `rsp_err` = 1. Write responses carry `rsp_rdata` = 0.
- R7: `req_size` is encoded as 0 = byte, 1 = halfword, 2 or 3 = dword. A dword write issues only the address write and then a data write of `req_wdata` to 0x1AC, with no master read and `rsp_err` = 0.
- R8: A byte or halfword write first reads 0x1AC and runs the R5 status checks. If an error is found, no write to 0x1AC follows and the response has `rsp_err` = 1.
- R9: If that read succeeds, the merged dword is written to 0x1AC. The lane at shift (offset & 3) × 8, 8 or 16 bits wide and cut off at bit 31, takes the low bytes of `req_wdata`. Write-data bits beyond the access size are ignored.
- R10: Synchronous reset, from any state, returns the block to idle. In the cycle after reset, `m_wr`, `m_rd` and `rsp_valid` are low and `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| root_bus | input | 8 | Number of the locally attached root bus |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Sequencer idle, request accepted when valid |
| req_bus | input | 8 | Target bus number |
| req_dev | input | 5 | Target device number |
| req_func | input | 3 | Target function number |
| req_off | input | 8 | Register byte offset |
| req_size | input | 2 | 0 byte, 1 halfword, 2/3 dword |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 32 | Write value, in the low bits |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_err | output | 1 | Error found by the status checks |
| rsp_rdata | output | 32 | Aligned read data or all ones |
| m_wr | output | 1 | Master write strobe |
| m_rd | output | 1 | Master read strobe |
| m_addr | output | 12 | Master register offset |
| m_wdata | output | 32 | Master write data |
| m_rdata | input | 32 | Master read data |
| m_rvalid | input | 1 | Master read data valid |

## Verification
The assertions assume that the register port answers every read with a single `m_rvalid` pulse that comes at least one cycle after the read strobe, and never without a read outstanding. They also assume that `req_valid` is offered only while `req_ready` is high. The bench's register model queues one reply per observed read strobe and releases it after a programmable latency of zero or more extra cycles. The bench raises a request only between responses, and clears its model on reset so that no stale reply reaches the design.

// File: rtl/pci_cfg_pkg.sv
package pci_cfg_pkg;
  localparam int DW    = 32;
  localparam int BUS_W = 8;
  localparam int DEV_W = 5;
  localparam int FN_W  = 3;
  localparam int OFF_W = 8;
  localparam int SZ_W  = 2;
  localparam int SH_W  = $clog2(DW);

  // Type 0 or Type 1 configuration address word
  function automatic logic [DW-1:0] cfg_addr(input logic [BUS_W-1:0] bus,
                                             input logic [BUS_W-1:0] root,
                                             input logic [DEV_W-1:0] dev,
                                             input logic [FN_W-1:0]  fn,
                                             input logic [OFF_W-1:0] off);
    logic [DW-1:0] a;
    if (bus == root) begin
      a = {16'd0, dev, fn, off[7:2], 2'b00};
      if (!dev[4]) a[{1'b1, dev[3:0]}] = 1'b1;
    end else begin
      a = {8'd0, bus, dev, fn, off[7:2], 1'b0, 1'b1};
    end
    return a;
  endfunction

  function automatic logic [SH_W-1:0] lane_shift(input logic [1:0] off);
    return {off, 3'b000};
  endfunction

  function automatic logic [DW-1:0] lane_mask(input logic [SZ_W-1:0] size,
                                              input logic [1:0] off);
    logic [DW-1:0] base;
    case (size)
      2'd0:    base = 32'h0000_00FF;
      2'd1:    base = 32'h0000_FFFF;
      default: base = '1;
    endcase
    return base << lane_shift(off);
  endfunction

  function automatic logic [DW-1:0] lane_merge(input logic [DW-1:0] old,
                                               input logic [DW-1:0] wd,
                                               input logic [SZ_W-1:0] size,
                                               input logic [1:0] off);
    logic [DW-1:0] m;
    m = lane_mask(size, off);
    return (old & ~m) | ((wd << lane_shift(off)) & m);
  endfunction

  function automatic logic [DW-1:0] lane_align(input logic [DW-1:0] d,
                                               input logic [1:0] off);
    return d >> lane_shift(off);
  endfunction
endpackage

// File: rtl/pci_cfg_addr_enc.sv
module pci_cfg_addr_enc
  import pci_cfg_pkg::*;
(
  input  logic [BUS_W-1:0] bus,
  input  logic [BUS_W-1:0] root,
  input  logic [DEV_W-1:0] dev,
  input  logic [FN_W-1:0]  fn,
  input  logic [OFF_W-1:0] off,
  output logic [DW-1:0]    addr_word
);
  always_comb addr_word = cfg_addr(bus, root, dev, fn, off);
endmodule

// File: rtl/pci_cfg_lane.sv
module pci_cfg_lane
  import pci_cfg_pkg::*;
(
  input  logic [DW-1:0]   dword,
  input  logic [DW-1:0]   wdata,
  input  logic [SZ_W-1:0] size,
  input  logic [1:0]      off_lo,
  output logic [DW-1:0]   aligned,
  output logic [DW-1:0]   merged
);
  always_comb begin
    aligned = lane_align(dword, off_lo);
    merged  = lane_merge(dword, wdata, size, off_lo);
  end
endmodule

// File: rtl/pci_cfg_fsm.sv
module pci_cfg_fsm
  import pci_cfg_pkg::*;
#(
  parameter int REG_AW = 12,
  parameter logic [REG_AW-1:0] ADDR_REG = 'h1A4,
  parameter logic [REG_AW-1:0] DATA_REG = 'h1AC,
  parameter logic [REG_AW-1:0] PSR_REG  = 'h106,
  parameter logic [REG_AW-1:0] ISR_REG  = 'h188,
  parameter logic [DW-1:0] PSR_MASK = 32'h0000_F900,
  parameter logic [DW-1:0] ISR_MASK = 32'h0000_679F
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [BUS_W-1:0]  req_bus,
  input  logic [DEV_W-1:0]  req_dev,
  input  logic [FN_W-1:0]   req_func,
  input  logic [OFF_W-1:0]  req_off,
  input  logic [SZ_W-1:0]   req_size,
  input  logic              req_write,
  input  logic [DW-1:0]     req_wdata,
  output logic              rsp_valid,
  output logic              rsp_err,
  output logic [DW-1:0]     rsp_rdata,
  output logic              m_wr,
  output logic              m_rd,
  output logic [REG_AW-1:0] m_addr,
  output logic [DW-1:0]     m_wdata,
  input  logic [DW-1:0]     m_rdata,
  input  logic              m_rvalid,
  input  logic [DW-1:0]     addr_word,
  input  logic [DW-1:0]     aligned,
  input  logic [DW-1:0]     merged,
  output logic [BUS_W-1:0]  q_bus,
  output logic [DEV_W-1:0]  q_dev,
  output logic [FN_W-1:0]   q_fn,
  output logic [OFF_W-1:0]  q_off,
  output logic [SZ_W-1:0]   q_size,
  output logic [DW-1:0]     q_wd,
  output logic [DW-1:0]     dword_q,
  output logic              cur_write,
  output logic              cur_word,
  output logic              psr_hit_evt,
  output logic              isr_hit_evt
);
  typedef enum logic [3:0] {
    S_IDLE, S_WADDR, S_RDATA, S_WTDATA, S_RPSR, S_WTPSR, S_CPSR,
    S_RISR, S_WTISR, S_CISR, S_WDATA, S_RESP
  } st_e;

  st_e st, st_nx;
  logic          q_wr, err_q, fail_now;
  logic [DW-1:0] psr_clr, isr_clr, psr_hits, isr_hits;

  assign psr_hits    = m_rdata & PSR_MASK;
  assign isr_hits    = m_rdata & ISR_MASK;
  assign psr_hit_evt = (st == S_WTPSR) && m_rvalid && (psr_hits != '0);
  assign isr_hit_evt = (st == S_WTISR) && m_rvalid && (isr_hits != '0);
  assign fail_now    = err_q | isr_hit_evt;
  assign cur_write   = q_wr;
  assign cur_word    = q_size[1];

  always_comb begin
    st_nx = st;
    case (st)
      S_IDLE:   if (req_valid) st_nx = S_WADDR;
      S_WADDR:  st_nx = (q_wr && q_size[1]) ? S_WDATA : S_RDATA;
      S_RDATA:  st_nx = S_WTDATA;
      S_WTDATA: if (m_rvalid) st_nx = S_RPSR;
      S_RPSR:   st_nx = S_WTPSR;
      S_WTPSR:  if (m_rvalid) st_nx = psr_hit_evt ? S_CPSR : S_RISR;
      S_CPSR:   st_nx = S_RISR;
      S_RISR:   st_nx = S_WTISR;
      S_WTISR:  if (m_rvalid) st_nx = isr_hit_evt ? S_CISR :
                                     ((q_wr && !fail_now) ? S_WDATA : S_RESP);
      S_CISR:   st_nx = (q_wr && !err_q) ? S_WDATA : S_RESP;
      S_WDATA:  st_nx = S_RESP;
      S_RESP:   st_nx = S_IDLE;
      default:  st_nx = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st    <= S_IDLE;
      err_q <= 1'b0;
    end else begin
      st <= st_nx;
      if (st == S_IDLE && req_valid) begin
        q_bus  <= req_bus;
        q_dev  <= req_dev;
        q_fn   <= req_func;
        q_off  <= req_off;
        q_size <= req_size;
        q_wr   <= req_write;
        q_wd   <= req_wdata;
        err_q  <= 1'b0;
      end
      if (st == S_WTDATA && m_rvalid) dword_q <= m_rdata;
      if (st == S_WTPSR && m_rvalid) begin
        psr_clr <= psr_hits;
        if (psr_hit_evt) err_q <= 1'b1;
      end
      if (st == S_WTISR && m_rvalid) begin
        isr_clr <= isr_hits;
        if (isr_hit_evt) err_q <= 1'b1;
      end
    end
  end

  always_comb begin
    m_wr    = 1'b0;
    m_rd    = 1'b0;
    m_addr  = DATA_REG;
    m_wdata = '0;
    case (st)
      S_WADDR: begin m_wr = 1'b1; m_addr = ADDR_REG; m_wdata = addr_word; end
      S_RDATA: m_rd = 1'b1;
      S_RPSR:  begin m_rd = 1'b1; m_addr = PSR_REG; end
      S_CPSR:  begin m_wr = 1'b1; m_addr = PSR_REG; m_wdata = psr_clr; end
      S_RISR:  begin m_rd = 1'b1; m_addr = ISR_REG; end
      S_CISR:  begin m_wr = 1'b1; m_addr = ISR_REG; m_wdata = isr_clr; end
      S_WDATA: begin m_wr = 1'b1; m_wdata = q_size[1] ? q_wd : merged; end
      default: ;
    endcase
  end

  assign req_ready = (st == S_IDLE);
  assign rsp_valid = (st == S_RESP);
  assign rsp_err   = rsp_valid && err_q;
  assign rsp_rdata = (!rsp_valid || q_wr) ? '0 : (err_q ? '1 : aligned);
endmodule

// File: rtl/pci_cfg_seq.sv
module pci_cfg_seq
  import pci_cfg_pkg::*;
#(
  parameter int REG_AW = 12,
  parameter logic [REG_AW-1:0] ADDR_REG = 'h1A4,
  parameter logic [REG_AW-1:0] DATA_REG = 'h1AC,
  parameter logic [REG_AW-1:0] PSR_REG  = 'h106,
  parameter logic [REG_AW-1:0] ISR_REG  = 'h188
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [BUS_W-1:0]  root_bus,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [BUS_W-1:0]  req_bus,
  input  logic [DEV_W-1:0]  req_dev,
  input  logic [FN_W-1:0]   req_func,
  input  logic [OFF_W-1:0]  req_off,
  input  logic [SZ_W-1:0]   req_size,
  input  logic              req_write,
  input  logic [DW-1:0]     req_wdata,
  output logic              rsp_valid,
  output logic              rsp_err,
  output logic [DW-1:0]     rsp_rdata,
  output logic              m_wr,
  output logic              m_rd,
  output logic [REG_AW-1:0] m_addr,
  output logic [DW-1:0]     m_wdata,
  input  logic [DW-1:0]     m_rdata,
  input  logic              m_rvalid
);
  logic [BUS_W-1:0] q_bus;
  logic [DEV_W-1:0] q_dev;
  logic [FN_W-1:0]  q_fn;
  logic [OFF_W-1:0] q_off;
  logic [SZ_W-1:0]  q_size;
  logic [DW-1:0]    q_wd, dword_q, addr_word, aligned, merged;
  logic             cur_write, cur_word, psr_hit_evt, isr_hit_evt;

  pci_cfg_addr_enc enc_i (
    .bus(q_bus), .root(root_bus), .dev(q_dev), .fn(q_fn), .off(q_off),
    .addr_word(addr_word)
  );

  pci_cfg_lane lane_i (
    .dword(dword_q), .wdata(q_wd), .size(q_size), .off_lo(q_off[1:0]),
    .aligned(aligned), .merged(merged)
  );

  pci_cfg_fsm #(
    .REG_AW(REG_AW), .ADDR_REG(ADDR_REG), .DATA_REG(DATA_REG),
    .PSR_REG(PSR_REG), .ISR_REG(ISR_REG)
  ) fsm_i (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_bus(req_bus), .req_dev(req_dev), .req_func(req_func),
    .req_off(req_off), .req_size(req_size), .req_write(req_write),
    .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
    .m_wr(m_wr), .m_rd(m_rd), .m_addr(m_addr), .m_wdata(m_wdata),
    .m_rdata(m_rdata), .m_rvalid(m_rvalid),
    .addr_word(addr_word), .aligned(aligned), .merged(merged),
    .q_bus(q_bus), .q_dev(q_dev), .q_fn(q_fn), .q_off(q_off),
    .q_size(q_size), .q_wd(q_wd), .dword_q(dword_q),
    .cur_write(cur_write), .cur_word(cur_word),
    .psr_hit_evt(psr_hit_evt), .isr_hit_evt(isr_hit_evt)
  );
endmodule

// File: rtl/pci_cfg_seq_chk.sv
module pci_cfg_seq_chk #(
  parameter int REG_AW = 12,
  parameter logic [REG_AW-1:0] DATA_REG = 'h1AC,
  parameter logic [REG_AW-1:0] PSR_REG  = 'h106,
  parameter logic [REG_AW-1:0] ISR_REG  = 'h188
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic              rsp_err,
  input logic [31:0]       rsp_rdata,
  input logic              m_wr,
  input logic              m_rd,
  input logic [REG_AW-1:0] m_addr,
  input logic              cur_write,
  input logic              cur_word,
  input logic              psr_hit_evt,
  input logic              isr_hit_evt
);
  // R1
  rsp_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid);
  // R1
  accept_busy_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> !req_ready);
  // R4
  strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(m_wr && m_rd));
  // R5
  psr_clear_chk: assert property (@(posedge clk) disable iff (rst)
    psr_hit_evt |=> (m_wr && m_addr == PSR_REG));
  // R5
  isr_clear_chk: assert property (@(posedge clk) disable iff (rst)
    isr_hit_evt |=> (m_wr && m_addr == ISR_REG));
  // R6
  err_ones_chk: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_err && !cur_write) |-> (rsp_rdata == 32'hFFFF_FFFF));
  // R7
  word_wr_noread_chk: assert property (@(posedge clk) disable iff (rst)
    (m_rd && m_addr == DATA_REG) |-> !(cur_write && cur_word));
  // R10
  reset_idle_chk: assert property (@(posedge clk)
    rst |=> (!m_wr && !m_rd && !rsp_valid && req_ready));
endmodule

bind pci_cfg_seq pci_cfg_seq_chk #(
  .REG_AW(REG_AW), .DATA_REG(DATA_REG), .PSR_REG(PSR_REG), .ISR_REG(ISR_REG)
) chk_i (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
  .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
  .m_wr(m_wr), .m_rd(m_rd), .m_addr(m_addr),
  .cur_write(cur_write), .cur_word(cur_word),
  .psr_hit_evt(psr_hit_evt), .isr_hit_evt(isr_hit_evt)
);

// File: tb/pci_cfg_seq_tb_top.sv
`timescale 1ns/1ps
module pci_cfg_seq_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  root_bus = 8'd0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [7:0]  req_bus = '0;
  logic [4:0]  req_dev = '0;
  logic [2:0]  req_func = '0;
  logic [7:0]  req_off = '0;
  logic [1:0]  req_size = '0;
  logic        req_write = 1'b0;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid, rsp_err;
  logic [31:0] rsp_rdata;
  logic        m_wr, m_rd;
  logic [11:0] m_addr;
  logic [31:0] m_wdata;
  logic [31:0] m_rdata = '0;
  logic        m_rvalid = 1'b0;

  always #5 clk = ~clk;

  pci_cfg_seq dut_i (
    .clk(clk), .rst(rst), .root_bus(root_bus),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_bus(req_bus), .req_dev(req_dev), .req_func(req_func),
    .req_off(req_off), .req_size(req_size), .req_write(req_write),
    .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
    .m_wr(m_wr), .m_rd(m_rd), .m_addr(m_addr), .m_wdata(m_wdata),
    .m_rdata(m_rdata), .m_rvalid(m_rvalid)
  );

  typedef struct packed { logic wr; logic [11:0] addr; logic [31:0] data; } txn_t;
  txn_t exp_q[$];

  int    checks = 0;
  int    failures = 0;
  bit    done = 1'b0;
  string cur_tag = "R4";

  // register model state
  logic [31:0] s_dword, s_psr, s_isr;
  int          s_lat = 0;
  bit          pend = 1'b0;
  int          cnt = 0;
  logic [31:0] pend_val = '0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // model of the register port, compared against the expected queue every clock
  always @(negedge clk) begin
    if (rst) begin
      pend = 1'b0;
      m_rvalid = 1'b0;
    end else begin
      m_rvalid = 1'b0;
      if (pend) begin
        if (cnt == 0) begin
          m_rvalid = 1'b1;
          m_rdata = pend_val;
          pend = 1'b0;
        end else cnt--;
      end
      chk(!(m_wr && m_rd), "R4", "both strobes", {30'd0, m_wr, m_rd}, 32'd0);
      if (m_wr || m_rd) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, cur_tag, "unexpected strobe addr", {20'd0, m_addr}, 32'd0);
        end else begin
          txn_t e;
          e = exp_q.pop_front();
          chk(m_wr == e.wr && m_addr == e.addr, cur_tag, "strobe kind/addr",
              {19'd0, m_wr, m_addr}, {19'd0, e.wr, e.addr});
          if (m_wr)
            chk(m_wdata == e.data, cur_tag, "write data", m_wdata, e.data);
        end
        if (m_wr && m_addr == 12'h106) s_psr = s_psr & ~m_wdata;
        if (m_wr && m_addr == 12'h188) s_isr = s_isr & ~m_wdata;
        if (m_wr && m_addr == 12'h1AC) s_dword = m_wdata;
        if (m_rd) begin
          pend = 1'b1;
          cnt = s_lat;
          case (m_addr)
            12'h1AC: pend_val = s_dword;
            12'h106: pend_val = s_psr;
            12'h188: pend_val = s_isr;
            default: pend_val = '0;
          endcase
        end
      end
    end
  end

  function automatic logic [31:0] ref_addr(input logic [7:0] bus, input logic [7:0] root,
      input logic [4:0] dev, input logic [2:0] fn, input logic [7:0] off);
    logic [31:0] a;
    a = 32'(dev) * 2048 + 32'(fn) * 256 + 32'(off & 8'hFC);
    if (bus == root) begin
      for (int i = 0; i < 16; i++) if (int'(dev) == i) a[16+i] = 1'b1;
    end else begin
      a = a + 32'(bus) * 65536 + 1;
    end
    return a;
  endfunction

  function automatic logic [31:0] ref_merge(input logic [31:0] old, input logic [31:0] wd,
      input logic [1:0] sz, input logic [7:0] off);
    logic [31:0] r;
    int o, n;
    o = int'(off[1:0]);
    n = (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
    r = old;
    for (int b = 0; b < 4; b++)
      if (b >= o && b < o + n) r[8*b +: 8] = wd[8*(b-o) +: 8];
    return r;
  endfunction

  task automatic run_req(input logic [7:0] bus, input logic [4:0] dev, input logic [2:0] fn,
      input logic [7:0] off, input logic [1:0] sz, input bit wr, input logic [31:0] wd,
      input logic [31:0] dword, input logic [31:0] psr, input logic [31:0] isr,
      input int lat, input string tag);
    logic [31:0] ph, ih, exp_rd;
    bit e;
    int n;
    cur_tag = tag;
    s_dword = dword; s_psr = psr; s_isr = isr; s_lat = lat;
    exp_q.push_back({1'b1, 12'h1A4, ref_addr(bus, root_bus, dev, fn, off)});
    e = 1'b0;
    if (wr && sz[1]) begin
      exp_q.push_back({1'b1, 12'h1AC, wd});
    end else begin
      exp_q.push_back({1'b0, 12'h1AC, 32'd0});
      exp_q.push_back({1'b0, 12'h106, 32'd0});
      ph = psr & 32'hF900;
      if (ph != 0) exp_q.push_back({1'b1, 12'h106, ph});
      exp_q.push_back({1'b0, 12'h188, 32'd0});
      ih = isr & 32'h679F;
      if (ih != 0) exp_q.push_back({1'b1, 12'h188, ih});
      e = (ph != 0) || (ih != 0);
      if (wr && !e) exp_q.push_back({1'b1, 12'h1AC, ref_merge(dword, wd, sz, off)});
    end
    exp_rd = wr ? 32'd0 : (e ? 32'hFFFF_FFFF : (dword >> (8 * int'(off[1:0]))));
    @(negedge clk);
    chk(req_ready == 1'b1, "R1", "ready while idle", {31'd0, req_ready}, 32'd1);
    req_bus = bus; req_dev = dev; req_func = fn; req_off = off;
    req_size = sz; req_write = wr; req_wdata = wd; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk(req_ready == 1'b0, "R1", "busy after accept", {31'd0, req_ready}, 32'd0);
    n = 0;
    while (!rsp_valid && n < 300) begin @(negedge clk); n++; end
    chk(rsp_valid == 1'b1, "R1", "response seen", {31'd0, rsp_valid}, 32'd1);
    chk(rsp_rdata == exp_rd, tag, "rsp_rdata", rsp_rdata, exp_rd);
    chk(rsp_err == e, tag, "rsp_err", {31'd0, rsp_err}, {31'd0, e});
    chk(exp_q.size() == 0, tag, "missing strobes", exp_q.size(), 32'd0);
    exp_q.delete();
    @(negedge clk);
    chk(rsp_valid == 1'b0, "R1", "single-cycle response", {31'd0, rsp_valid}, 32'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!m_wr && !m_rd && !rsp_valid, "R10", "outputs in reset",
        {29'd0, m_wr, m_rd, rsp_valid}, 32'd0);
    rst = 1'b0;
    @(negedge clk);
    chk(req_ready == 1'b1, "R10", "ready after reset", {31'd0, req_ready}, 32'd1);

    // R2 Type 0 dword read
    run_req(8'd0, 5'd3, 3'd2, 8'h10, 2'd2, 1'b0, 32'd0, 32'h1234_5678, 0, 0, 0, "R2");
    // R3 Type 1 halfword read at lane 2 (R6 shift)
    run_req(8'd5, 5'd9, 3'd1, 8'h0E, 2'd1, 1'b0, 32'd0, 32'hBEEF_0011, 0, 0, 2, "R3");
    // R6 byte read at lane 3, upper bits beyond shift
    run_req(8'd7, 5'd30, 3'd7, 8'hFF, 2'd0, 1'b0, 32'd0, 32'hA1B2_C3D4, 0, 0, 1, "R6");
    // R5 primary status error only; unmasked bits stay set
    run_req(8'd0, 5'd1, 3'd0, 8'h00, 2'd2, 1'b0, 32'd0, 32'h5555_5555, 32'h0106, 0, 0, "R5");
    chk(s_psr == 32'h0006, "R5", "primary status after clear", s_psr, 32'h0006);
    // R5 interrupt status error only
    run_req(8'd3, 5'd2, 3'd0, 8'h04, 2'd2, 1'b0, 32'd0, 32'h0, 0, 32'h0804, 1, "R5");
    chk(s_isr == 32'h0800, "R5", "interrupt status after clear", s_isr, 32'h0800);
    // R6 both errors give all ones
    run_req(8'd0, 5'd4, 3'd3, 8'h08, 2'd0, 1'b0, 32'd0, 32'h0, 32'h8000, 32'h0001, 0, "R6");
    // R7 dword write, no reads
    run_req(8'd9, 5'd12, 3'd5, 8'h3C, 2'd2, 1'b1, 32'hCAFE_F00D, 32'h0, 0, 0, 0, "R7");
    // R7 size code 3 treated as dword
    run_req(8'd0, 5'd6, 3'd0, 8'h20, 2'd3, 1'b1, 32'h0BAD_CAFE, 32'h0, 0, 0, 0, "R7");
    // R9 byte write lane 1, high wdata bits ignored
    run_req(8'd0, 5'd5, 3'd1, 8'h41, 2'd0, 1'b1, 32'hABCD_EF5A, 32'h1122_3344, 0, 0, 1, "R9");
    // R9 halfword write at lane 3, cut at bit 31
    run_req(8'd2, 5'd8, 3'd0, 8'h43, 2'd1, 1'b1, 32'h0000_9876, 32'h1122_3344, 0, 0, 0, "R9");
    // R8 halfword write dropped on status error
    run_req(8'd0, 5'd7, 3'd2, 8'h12, 2'd1, 1'b1, 32'h0000_4444, 32'h7777_7777, 32'h1000, 0, 2, "R8");
    chk(s_dword == 32'h7777_7777, "R8", "data register untouched", s_dword, 32'h7777_7777);
    // R8 byte write dropped on interrupt status error
    run_req(8'd4, 5'd7, 3'd2, 8'h11, 2'd0, 1'b1, 32'h0000_0044, 32'h6666_6666, 0, 32'h0200, 0, "R8");
    // R2 device 15 selects bit 31, device 17 selects none
    run_req(8'd0, 5'd15, 3'd0, 8'h00, 2'd2, 1'b0, 32'd0, 32'h1, 0, 0, 0, "R2");
    run_req(8'd0, 5'd17, 3'd4, 8'h84, 2'd2, 1'b0, 32'd0, 32'h2, 0, 0, 0, "R2");
    // R2 non-zero root bus
    root_bus = 8'd2;
    run_req(8'd2, 5'd0, 3'd1, 8'h2C, 2'd2, 1'b0, 32'd0, 32'h3, 0, 0, 0, "R2");
    run_req(8'd0, 5'd0, 3'd1, 8'h2C, 2'd2, 1'b0, 32'd0, 32'h4, 0, 0, 0, "R3");
    root_bus = 8'd0;

    // R10 reset in mid-sequence
    cur_tag = "R10";
    s_lat = 6; s_dword = 32'h0; s_psr = 0; s_isr = 0;
    exp_q.push_back({1'b1, 12'h1A4, ref_addr(8'd0, 8'd0, 5'd1, 3'd0, 8'h00)});
    exp_q.push_back({1'b0, 12'h1AC, 32'd0});
    @(negedge clk);
    req_bus = 8'd0; req_dev = 5'd1; req_func = 3'd0; req_off = 8'h00;
    req_size = 2'd2; req_write = 1'b0; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b1;
    exp_q.delete();
    repeat (2) @(negedge clk);
    rst = 1'b0;
    chk(!m_wr && !m_rd && !rsp_valid && req_ready, "R10", "idle after mid reset",
        {28'd0, m_wr, m_rd, rsp_valid, req_ready}, 32'd1);
    repeat (8) @(negedge clk);
    chk(!rsp_valid, "R10", "no stale response", {31'd0, rsp_valid}, 32'd0);
    run_req(8'd1, 5'd2, 3'd3, 8'h18, 2'd2, 1'b0, 32'd0, 32'h0F0F_0F0F, 0, 0, 0, "R10");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule